// File: doc/BRIEF.md
# External DMA Request Acceptance Unit

This block is the per-channel front end that decides when an active-low external request line starts a transfer. The request pin is brought into the clock domain by a synchronizer chain. It is then qualified either by its low level or by a falling edge. A start pulse goes to the transfer engine, and the unit waits for that engine's completion pulse before it re-arms.

A small control register selects the mode and the re-arm timing. It also holds the active-low enables for the acknowledge and end-of-transfer pins, block mode and the address mode. In edge mode, the first request after the channel is enabled is still taken on a plain low level, and only later requests need a fresh falling edge. Block mode always uses level detection. A read-only active flag shows whether the channel is between an accepted request and its re-arm.

Top module: `dreq_accept_unit`

## Requirements
- R1: With level detection, a low request held through the synchronizer (two clock edges after the pin changes) makes `xferStart` high for one cycle while the channel waits and `xferEnable` is 1. A held low request is taken again each time the channel re-arms.
- R2: With register bit 0 (edge select) at 1, the first request after enabling is taken on a low level. Each later request needs a new high-to-low transition of the synchronized line. An edge seen while a transfer runs is remembered until the channel re-arms.
- R3: With register bit 4 (block mode) at 1, detection is by level whatever bit 0 holds.
- R4: With register bit 1 (request delay) at 0, a request is accepted in the cycle after the `xferDone` pulse. At 1, it is accepted one cycle later.
- R5: Register read bit 6 (active) is 1 from the cycle after an acceptance until re-arm. It is 0 while waiting, and it is 0 one clock after `xferEnable` falls.
- R6: `ackN` is low in each transfer cycle only when register bit 5 (dual address) is 0 and bit 2 (acknowledge disable) is 0. Otherwise it stays high.
- R7: `endN` is low during a transfer cycle with `xferLast` high only when register bit 3 (end disable) is 0.
- R8: Register bits 7 and 6 ignore writes. Bit 7 reads 0, and bit 6 reads the active flag.
- R9: After reset the register reads 0, and `ackN`, `endN` are high and `xferStart` is low.
- R10: Clearing and then setting `xferEnable` restores the rule that the first request is taken on level, even in edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Control register write strobe |
| cfgWrData | input | 8 | Control register write data |
| cfgRdData | output | 8 | Control register readback with active flag |
| xferEnable | input | 1 | Channel transfer enable |
| xferDone | input | 1 | One-cycle completion pulse from the engine |
| xferLast | input | 1 | Current transfer is the final one |
| reqN | input | 1 | Active-low external request pin |
| xferStart | output | 1 | One-cycle accepted-request pulse |
| ackN | output | 1 | Active-low acknowledge pin |
| endN | output | 1 | Active-low end-of-transfer pin |

## Verification
A table of register settings is run with the request held low and a stub engine answering each start with a completion. Each setting is scored by its counts of starts, acknowledge cycles and end cycles over a fixed window. Those counts separate level from edge detection (repeated versus single acceptance), the request delay (period two versus three) and the forcing by block mode. The same counts also show the pin gating by the enable and address bits. Directed tests then drive a true high-to-low edge in edge mode and check the synchronizer latency. They also cover the active flag around disable and re-enable, and the reserved-bit readback.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  localparam int REG_W = 8;
  localparam int ACTIVE_BIT = 6;
  localparam logic [REG_W-1:0] WRITABLE_MASK = 8'h3F;

  typedef struct packed {
    logic dualAddr;
    logic blockMode;
    logic endOff;
    logic ackOff;
    logic holdOff;
    logic edgeSel;
  } cfgFields_t;

  typedef struct packed {
    logic acceptNow;
    logic busyNow;
    logic activeNow;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_BUSY = 2'd1,
    ST_HOLD = 2'd2
  } chanState_t;
endpackage

// File: rtl/dreq_datapath.sv
module dreq_datapath
  import dreq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [REG_W-1:0] cfgWrData,
  input  logic             xferEnable,
  input  logic             xferLast,
  input  logic             reqN,
  input  ctrlStrobes_t     strb,
  output cfgFields_t       cfg,
  output logic             reqHit,
  output logic [REG_W-1:0] cfgRdData,
  output logic             ackN,
  output logic             endN
);
  logic [REG_W-1:0]       cfgQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic reqSync, reqPrev, fall, firstReq, edgeSeen, useLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else if (cfgWrEn) cfgQ <= cfgWrData & WRITABLE_MASK;
  end

  assign cfg = cfgFields_t'(cfgQ[5:0]);

  always_comb begin
    cfgRdData = cfgQ;
    cfgRdData[ACTIVE_BIT] = strb.activeNow;
  end

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else syncQ <= {syncQ[SYNC_STAGES-2:0], reqN};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else syncQ <= reqN;
      end
    end
  endgenerate

  assign reqSync = syncQ[SYNC_STAGES-1];
  assign fall = reqPrev & ~reqSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqPrev  <= 1'b1;
      firstReq <= 1'b1;
      edgeSeen <= 1'b0;
    end else begin
      reqPrev <= reqSync;
      if (!xferEnable) begin
        firstReq <= 1'b1;
        edgeSeen <= 1'b0;
      end else if (strb.acceptNow) begin
        firstReq <= 1'b0;
        edgeSeen <= 1'b0;
      end else if (fall) begin
        edgeSeen <= 1'b1;
      end
    end
  end

  assign useLevel = ~cfg.edgeSel | cfg.blockMode | firstReq;
  assign reqHit = xferEnable & (useLevel ? ~reqSync : (edgeSeen | fall));

  assign ackN = ~(strb.busyNow & ~cfg.dualAddr & ~cfg.ackOff);
  assign endN = ~(strb.busyNow & xferLast & ~cfg.endOff);

  p_ack_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ackN |-> (!cfg.dualAddr && !cfg.ackOff && strb.activeNow));
  p_end_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    !endN |-> (xferLast && !cfg.endOff && strb.activeNow));
  p_edge_rule_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.acceptNow && cfg.edgeSel && !cfg.blockMode && !firstReq) |-> (edgeSeen || fall));
  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdData[7] == 1'b0);
endmodule

// File: rtl/dreq_control.sv
module dreq_control
  import dreq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         xferEnable,
  input  logic         reqHit,
  input  logic         xferDone,
  input  logic         holdOff,
  output ctrlStrobes_t strb,
  output logic         xferStart
);
  chanState_t state, stateNext;

  always_comb begin
    stateNext = state;
    if (!xferEnable) stateNext = ST_WAIT;
    else begin
      unique case (state)
        ST_WAIT: if (reqHit) stateNext = ST_BUSY;
        ST_BUSY: if (xferDone) stateNext = holdOff ? ST_HOLD : ST_WAIT;
        ST_HOLD: stateNext = ST_WAIT;
        default: stateNext = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WAIT;
    else state <= stateNext;
  end

  assign strb.acceptNow = (state == ST_WAIT) & reqHit;
  assign strb.busyNow   = (state == ST_BUSY);
  assign strb.activeNow = (state != ST_WAIT);
  assign xferStart      = strb.acceptNow;

  p_hold_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busyNow && xferDone && holdOff && xferEnable) |=> !xferStart);
  p_disable_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !xferEnable |=> !strb.activeNow);
  p_start_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> !xferStart);
  p_start_active_r5: assert property (@(posedge clk) disable iff (!rstN)
    (xferStart && xferEnable) |=> strb.activeNow);
endmodule

// File: rtl/dreq_accept_unit.sv
module dreq_accept_unit
  import dreq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [7:0] cfgWrData,
  output logic [7:0] cfgRdData,
  input  logic       xferEnable,
  input  logic       xferDone,
  input  logic       xferLast,
  input  logic       reqN,
  output logic       xferStart,
  output logic       ackN,
  output logic       endN
);
  ctrlStrobes_t strb;
  cfgFields_t   cfg;
  logic         reqHit;

  dreq_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .xferEnable(xferEnable), .xferLast(xferLast), .reqN(reqN), .strb(strb),
    .cfg(cfg), .reqHit(reqHit), .cfgRdData(cfgRdData), .ackN(ackN), .endN(endN)
  );

  dreq_control i_control (
    .clk(clk), .rstN(rstN), .xferEnable(xferEnable), .reqHit(reqHit),
    .xferDone(xferDone), .holdOff(cfg.holdOff), .strb(strb), .xferStart(xferStart)
  );
endmodule

// File: tb/test_dreq_accept_unit.sv
module test_dreq_accept_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic [7:0] cfgRdData;
  logic xferEnable = 1'b0, xferDone = 1'b0, xferLast = 1'b0, reqN = 1'b1;
  logic xferStart, ackN, endN;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dreq_accept_unit i_dreq_accept_unit (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .xferEnable(xferEnable), .xferDone(xferDone),
    .xferLast(xferLast), .reqN(reqN), .xferStart(xferStart), .ackN(ackN), .endN(endN)
  );

  // {cfg[5:0], starts, acks, ends} over a 12-cycle window, request held low
  localparam int NV = 9;
  localparam logic [17:0] VEC [NV] = '{
    {6'b000000, 4'd6, 4'd6, 4'd6},  // R1 level repeats every 2
    {6'b000010, 4'd4, 4'd4, 4'd4},  // R4 delay -> every 3
    {6'b000001, 4'd1, 4'd1, 4'd1},  // R2 edge: only the level-taken first
    {6'b010001, 4'd6, 4'd6, 4'd6},  // R3 block forces level
    {6'b010011, 4'd4, 4'd4, 4'd4},  // R3 R4
    {6'b100000, 4'd6, 4'd0, 4'd6},  // R6 dual address
    {6'b000100, 4'd6, 4'd0, 4'd6},  // R6 ack disabled
    {6'b001000, 4'd6, 4'd6, 4'd0},  // R7 end disabled
    {6'b000011, 4'd1, 4'd1, 4'd1}   // R2 R4
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic writeCfg(input logic [7:0] v);
    cyc(); cfgWrEn = 1'b1; cfgWrData = v;
    cyc(); cfgWrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    // R9 reset state
    check(cfgRdData == 8'h00, "R9 reg", cfgRdData, 0);
    check(ackN && endN && !xferStart, "R9 pins", {ackN, endN, xferStart}, 6);
    rstN = 1'b1;
    cyc();
    // R8 reserved bits ignore writes
    writeCfg(8'hFF);
    #2 check(cfgRdData == 8'h3F, "R8 readback", cfgRdData, 8'h3F);
    writeCfg(8'h00);

    reqN = 1'b0;
    for (int v = 0; v < NV; v++) begin
      int s, a, e;
      bit prevStart;
      s = 0; a = 0; e = 0; prevStart = 0;
      writeCfg({2'b00, VEC[v][17:12]});
      repeat (4) cyc();
      for (int c = 0; c < 12; c++) begin
        cyc();
        xferEnable = 1'b1; xferLast = 1'b1; xferDone = prevStart;
        #2;
        s += int'(xferStart); a += int'(!ackN); e += int'(!endN);
        prevStart = xferStart;
      end
      check(s == int'(VEC[v][11:8]), $sformatf("R1/R2/R3/R4 starts vec%0d", v), s, VEC[v][11:8]);
      check(a == int'(VEC[v][7:4]), $sformatf("R6 acks vec%0d", v), a, VEC[v][7:4]);
      check(e == int'(VEC[v][3:0]), $sformatf("R7 ends vec%0d", v), e, VEC[v][3:0]);
      cyc(); xferEnable = 1'b0; xferDone = 1'b0; xferLast = 1'b0;
      cyc();
      #2 check(cfgRdData[6] == 1'b0, "R5 active clears on disable", cfgRdData[6], 0);
    end

    // R2 edge mode: later request needs a real falling edge
    writeCfg(8'h01);
    cyc(); xferEnable = 1'b1;
    #2 check(xferStart, "R2 first request by level", xferStart, 1);
    cyc();
    #2 check(cfgRdData[6], "R5 active after accept", cfgRdData[6], 1);
    xferDone = 1'b1;
    cyc(); xferDone = 1'b0;
    #2 check(!xferStart && !cfgRdData[6], "R2 no retake without edge", xferStart, 0);
    reqN = 1'b1;
    repeat (3) cyc();
    reqN = 1'b0;
    cyc();
    #2 check(!xferStart, "R1 sync latency one edge", xferStart, 0);
    cyc();
    #2 check(xferStart, "R2 falling edge accepted", xferStart, 1);
    cyc(); xferDone = 1'b1;
    cyc(); xferDone = 1'b0;
    // R10 re-enable restores level rule
    xferEnable = 1'b0;
    cyc(); xferEnable = 1'b1;
    #2 check(xferStart, "R10 level after re-enable", xferStart, 1);
    cyc(); xferEnable = 1'b0;

    repeat (2) cyc();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule